// File: doc/BRIEF.md
# Byte-Lane Inversion Encoder for Compressed Lines

This block prepares one compressed cache line, up to 64 bytes long, for transmission one byte per beat over an 8-bit memory data path. To cut switching energy, it may send individual payload bytes bit-inverted. It records each inversion decision in a flag bit, and the flag bytes travel inside the line itself. The number of flag bytes (0 to 3) is chosen per line. It is the largest count that still fits in the padding between the compressed length and the next 8-byte boundary, so the flags never add a burst.

A line is offered in parallel together with its compressed length and a one-cycle start strobe. The encoder first scans the payload, one byte per cycle, to decide the inversions. It then emits the encoded stream in this order: the header byte with the mode written into its two low bits, the flag bytes, the payload (possibly inverted), and zero padding up to the burst boundary. A one-cycle done pulse follows the last beat.

Top module: `dbi_line_encoder`

## Requirements
- R1: For a line length L (1..64), `total_len_o` becomes the smallest multiple of 8 that is at least L. `mode_o` becomes min(3, total − L), and it gives the number of flag bytes.
- R2: The emitted stream is exactly `total_len_o` beats, in this order. Beat 0 is the header (line byte 0) with bits [1:0] replaced by the mode. The next `mode_o` beats are the flag bytes, flag byte 0 first. Then come line bytes 1..L−1 in order, and the rest of the beats are 8'h00.
- R3: An eligible payload byte is sent inverted if and only if sending it unchanged would toggle more than 4 of the 8 wires relative to the reference. At exactly 4 toggles, the byte goes out unchanged and its flag is 0.
- R4: The reference for a payload byte is the previous payload byte as actually driven, after any inversion. For the first payload byte the reference is 8'h00. Bytes that are not eligible are sent unchanged and still become the next reference. Header and flag bytes are never inverted.
- R5: Payload byte j (counting from 0 after the header) is eligible as follows. In mode 3, j < 24 is eligible. In mode 2, j < 16 is eligible when there are at most 16 payload bytes; otherwise even j < 32 is eligible. In mode 1, j < 8 is eligible when there are at most 8 payload bytes; otherwise j < 24 with j divisible by 3 is eligible. In mode 0, no byte is eligible.
- R6: Flag slot s is j in full coverage, j/2 in alternate coverage and j/3 in every-third coverage. Slot s sits in flag byte s/8 at bit s%8. `flags_o[8m+7:8m]` carries flag byte m after the scan, and slots not set are 0.
- R7: `out_valid_o` is high on consecutive cycles for exactly `total_len_o` beats. `done_o` pulses for one cycle, in the cycle right after the last valid beat.
- R8: A start strobe while `busy_o` is high is ignored. The line in progress is emitted unchanged, and `mode_o` holds still while busy.
- R9: After reset, `busy_o`, `out_valid_o`, `done_o`, `mode_o` and `total_len_o` are 0.
- R10: A length of 0 is treated as 1, and a length above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Accept a new line when idle |
| len_i | input | 7 | Compressed line length in bytes, header included |
| line_i | input | 512 | Line bytes; byte n at bits [8n+7:8n], byte 0 is the header |
| busy_o | output | 1 | Line in progress |
| out_valid_o | output | 1 | Output byte valid this cycle |
| out_byte_o | output | 8 | Encoded stream byte |
| mode_o | output | 2 | Number of flag bytes for the current line |
| flags_o | output | 24 | Flag bytes, byte m at bits [8m+7:8m] |
| total_len_o | output | 7 | Encoded length in bytes, multiple of 8 |
| done_o | output | 1 | One-cycle pulse after the last beat |

## Verification
The assertions watch the framing on every cycle. They check that the beat count at done equals the reported length, that done follows the last valid beat, and that the chosen mode fits in the padding of the captured length. They also check that a busy period only begins from a start and that the mode stays fixed during it. Whether a given byte is inverted, and where its flag bit lands, depends on the data history. Only the bench's scenarios can show this: ties at four toggles, chained references after an inversion, alternate and every-third coverage, and a start strobe injected mid-line.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int LINE_BYTES     = 64;
  localparam int BURST_BYTES    = 8;
  localparam int MAX_FLAG_BYTES = 3;
  localparam int FLAG_BITS      = 8 * MAX_FLAG_BYTES;
  localparam int LINE_W         = 8 * LINE_BYTES;
  localparam int LEN_W          = $clog2(LINE_BYTES + 1);
  localparam int IDX_W          = $clog2(LINE_BYTES);
  localparam int SLOT_W         = $clog2(FLAG_BITS);
  localparam int TOGGLE_LIMIT   = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_EMIT} enc_state_t;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } cover_t;

  // Coverage rule: which payload byte owns which flag slot for a mode.
  function automatic cover_t cover_of(input logic [1:0] mode,
                                      input logic [LEN_W-1:0] pay,
                                      input logic [IDX_W-1:0] j);
    cover_t r;
    int jj;
    int pp;
    int span;
    r    = '0;
    jj   = int'(j);
    pp   = int'(pay);
    span = 8 * int'(mode);
    case (mode)
      2'd3: begin
        if (jj < span) begin r.hit = 1'b1; r.slot = SLOT_W'(jj); end
      end
      2'd2: begin
        if (pp <= span) begin
          if (jj < span) begin r.hit = 1'b1; r.slot = SLOT_W'(jj); end
        end else if ((jj % 2) == 0 && jj < 2 * span) begin
          r.hit = 1'b1; r.slot = SLOT_W'(jj / 2);
        end
      end
      2'd1: begin
        if (pp <= span) begin
          if (jj < span) begin r.hit = 1'b1; r.slot = SLOT_W'(jj); end
        end else if ((jj % 3) == 0 && jj < 3 * span) begin
          r.hit = 1'b1; r.slot = SLOT_W'(jj / 3);
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dbi_mode_sel.sv
module dbi_mode_sel
  import dbi_pkg::*;
(
  input  logic [LEN_W-1:0] len_raw_i,
  output logic [LEN_W-1:0] len_eff_o,
  output logic [LEN_W-1:0] total_o,
  output logic [1:0]       mode_o
);
  localparam int BURST_SH = $clog2(BURST_BYTES);

  logic [LEN_W:0]   rounded;
  logic [LEN_W-1:0] spare;

  always_comb begin
    if (len_raw_i == '0)
      len_eff_o = LEN_W'(1);
    else if (int'(len_raw_i) > LINE_BYTES)
      len_eff_o = LEN_W'(LINE_BYTES);
    else
      len_eff_o = len_raw_i;
    rounded = ({1'b0, len_eff_o} + (LEN_W+1)'(BURST_BYTES - 1)) >> BURST_SH;
    total_o = LEN_W'(rounded << BURST_SH);
    spare   = total_o - len_eff_o;
    if (int'(spare) >= MAX_FLAG_BYTES)
      mode_o = 2'(MAX_FLAG_BYTES);
    else
      mode_o = spare[1:0];
  end
endmodule

// File: rtl/dbi_line_buf.sv
module dbi_line_buf
  import dbi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        hdr_o
);
  logic [7:0] mem [LINE_BYTES];

  for (genvar n = 0; n < LINE_BYTES; n++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        mem[n] <= '0;
      else if (load_i)
        mem[n] <= line_i[8*n +: 8];
    end
  end

  assign rdata_o = mem[raddr_i];
  assign hdr_o   = mem[0];
endmodule

// File: rtl/dbi_inv_decider.sv
module dbi_inv_decider
  import dbi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear_i,
  input  logic                  step_i,
  input  logic [1:0]            mode_i,
  input  logic [LEN_W-1:0]      pay_len_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [7:0]            data_i,
  output logic [FLAG_BITS-1:0]  flags_o,
  output logic [LINE_BYTES-1:0] inv_o
);
  logic [7:0] ref_q;
  cover_t     sel;
  logic       flip;
  logic [7:0] driven;

  always_comb begin
    sel    = cover_of(mode_i, pay_len_i, idx_i);
    flip   = sel.hit && ($countones(data_i ^ ref_q) > TOGGLE_LIMIT);
    driven = data_i ^ {8{flip}};
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      ref_q   <= '0;
      flags_o <= '0;
      inv_o   <= '0;
    end else if (step_i) begin
      ref_q        <= driven;
      inv_o[idx_i] <= flip;
      if (flip)
        flags_o[sel.slot] <= 1'b1;
    end
  end
endmodule

// File: rtl/dbi_beat_mux.sv
module dbi_beat_mux
  import dbi_pkg::*;
(
  input  logic [LEN_W-1:0]      beat_i,
  input  logic [1:0]            mode_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic [7:0]            hdr_i,
  input  logic [FLAG_BITS-1:0]  flags_i,
  input  logic [7:0]            data_i,
  input  logic [LINE_BYTES-1:0] inv_i,
  output logic [IDX_W-1:0]      addr_o,
  output logic [7:0]            byte_o
);
  logic [LEN_W-1:0] k_ext;
  logic [LEN_W-1:0] rel;
  logic [IDX_W-1:0] pidx;

  always_comb begin
    k_ext  = LEN_W'(mode_i);
    rel    = beat_i - k_ext;
    addr_o = rel[IDX_W-1:0];
    pidx   = addr_o - IDX_W'(1);
    if (beat_i == '0)
      byte_o = {hdr_i[7:2], mode_i};
    else if (beat_i <= k_ext) begin
      case (beat_i[1:0])
        2'd1:    byte_o = flags_i[7:0];
        2'd2:    byte_o = flags_i[15:8];
        default: byte_o = flags_i[23:16];
      endcase
    end else if (beat_i < len_i + k_ext)
      byte_o = data_i ^ {8{inv_i[pidx]}};
    else
      byte_o = 8'h00;
  end
endmodule

// File: rtl/dbi_line_encoder.sv
module dbi_line_encoder
  import dbi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [7:0]        out_byte_o,
  output logic [1:0]        mode_o,
  output logic [FLAG_BITS-1:0] flags_o,
  output logic [LEN_W-1:0]  total_len_o,
  output logic              done_o
);
  enc_state_t       state;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] pay_len;
  logic [LEN_W-1:0] len_eff;
  logic [LEN_W-1:0] total_c;
  logic [1:0]       mode_c;
  logic             load;
  logic [IDX_W-1:0] rd_addr;
  logic [IDX_W-1:0] emit_addr;
  logic [7:0]       rd_byte;
  logic [7:0]       hdr_byte;
  logic [7:0]       emit_byte;
  logic [LINE_BYTES-1:0] inv_vec;

  assign load    = (state == ST_IDLE) && start_i;
  assign pay_len = len_q - LEN_W'(1);
  assign rd_addr = (state == ST_SCAN) ? IDX_W'(idx + LEN_W'(1)) : emit_addr;
  assign busy_o  = (state != ST_IDLE);

  dbi_mode_sel u_mode_sel (
    .len_raw_i (len_i),
    .len_eff_o (len_eff),
    .total_o   (total_c),
    .mode_o    (mode_c)
  );

  dbi_line_buf u_line_buf (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .line_i  (line_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_byte),
    .hdr_o   (hdr_byte)
  );

  dbi_inv_decider u_decider (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (load),
    .step_i    (state == ST_SCAN),
    .mode_i    (mode_o),
    .pay_len_i (pay_len),
    .idx_i     (idx[IDX_W-1:0]),
    .data_i    (rd_byte),
    .flags_o   (flags_o),
    .inv_o     (inv_vec)
  );

  dbi_beat_mux u_beat_mux (
    .beat_i  (idx),
    .mode_i  (mode_o),
    .len_i   (len_q),
    .hdr_i   (hdr_byte),
    .flags_i (flags_o),
    .data_i  (rd_byte),
    .inv_i   (inv_vec),
    .addr_o  (emit_addr),
    .byte_o  (emit_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      idx         <= '0;
      len_q       <= '0;
      mode_o      <= '0;
      total_len_o <= '0;
      out_valid_o <= 1'b0;
      out_byte_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            len_q       <= len_eff;
            mode_o      <= mode_c;
            total_len_o <= total_c;
            idx         <= '0;
            state       <= (len_eff == LEN_W'(1)) ? ST_EMIT : ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (idx == pay_len - LEN_W'(1)) begin
            idx   <= '0;
            state <= ST_EMIT;
          end else begin
            idx <= idx + LEN_W'(1);
          end
        end
        ST_EMIT: begin
          if (idx < total_len_o) begin
            out_valid_o <= 1'b1;
            out_byte_o  <= emit_byte;
            idx         <= idx + LEN_W'(1);
          end else begin
            out_valid_o <= 1'b0;
            out_byte_o  <= '0;
            done_o      <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbi_encoder_checker.sv
module dbi_encoder_checker
  import dbi_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic             busy_o,
  input logic             out_valid_o,
  input logic [1:0]       mode_o,
  input logic [LEN_W-1:0] total_len_o,
  input logic             done_o
);
  logic [LEN_W-1:0] cap_len;
  logic [LEN_W:0]   beat_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_len  <= LEN_W'(1);
      beat_cnt <= '0;
    end else begin
      if (start_i && !busy_o) begin
        beat_cnt <= '0;
        if (len_i == '0)                      cap_len <= LEN_W'(1);
        else if (int'(len_i) > LINE_BYTES)    cap_len <= LEN_W'(LINE_BYTES);
        else                                  cap_len <= len_i;
      end else if (out_valid_o) begin
        beat_cnt <= beat_cnt + 1'b1;
      end
    end
  end

  // R7: done follows the last valid beat directly
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid_o) |-> done_o);

  // R7: beat count equals reported encoded length
  a_r7_beat_count: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (beat_cnt == {1'b0, total_len_o}));

  // R7: valid beats only while a line is in progress
  a_r7_valid_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> busy_o);

  // R1: length is burst aligned and the flags fit in the padding
  a_r1_fits_burst: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (total_len_o[2:0] == 3'd0) &&
               ({1'b0, cap_len} + (LEN_W+1)'(mode_o) <= {1'b0, total_len_o}) &&
               ({1'b0, total_len_o} < {1'b0, cap_len} + (LEN_W+1)'(BURST_BYTES)));

  // R8: a busy period only begins from a start strobe
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  // R8: mode holds while the line is in progress
  a_r8_mode_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(mode_o));
endmodule

bind dbi_line_encoder dbi_encoder_checker u_dbi_encoder_checker (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .len_i       (len_i),
  .busy_o      (busy_o),
  .out_valid_o (out_valid_o),
  .mode_o      (mode_o),
  .total_len_o (total_len_o),
  .done_o      (done_o)
);

// File: tb/test_dbi_line_encoder.sv
module test_dbi_line_encoder;
  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [6:0]   len_i;
  logic [511:0] line_i;
  logic         busy_o, out_valid_o, done_o;
  logic [7:0]   out_byte_o;
  logic [1:0]   mode_o;
  logic [23:0]  flags_o;
  logic [6:0]   total_len_o;

  int checks = 0;
  int errors = 0;
  bit hung = 0;

  logic [7:0]  exp_s [64];
  logic [7:0]  got_s [64];
  logic [1:0]  exp_mode;
  logic [6:0]  exp_total;
  logic [23:0] exp_flags;

  always #2.5 clk = ~clk;

  dbi_line_encoder i_dbi_line_encoder (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .line_i(line_i),
    .busy_o(busy_o), .out_valid_o(out_valid_o), .out_byte_o(out_byte_o),
    .mode_o(mode_o), .flags_o(flags_o), .total_len_o(total_len_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model written from R1-style rules (R1, R3, R4, R5, R6, R10)
  function automatic void model(input logic [511:0] line, input int len_raw);
    int L, P, k, slot;
    logic [7:0] prev, d, drv;
    logic [7:0] pay [64];
    bit elig, inv;
    L = (len_raw == 0) ? 1 : (len_raw > 64 ? 64 : len_raw);
    exp_total = 7'(((L + 7) / 8) * 8);
    k = int'(exp_total) - L;
    if (k > 3) k = 3;
    exp_mode = 2'(k);
    P = L - 1;
    prev = 8'h00;
    exp_flags = '0;
    for (int j = 0; j < P; j++) begin
      d = line[8*(j+1) +: 8];
      elig = 0; slot = 0;
      if (k == 3 && j < 24) begin elig = 1; slot = j; end
      if (k == 2) begin
        if (P <= 16 && j < 16) begin elig = 1; slot = j; end
        if (P > 16 && j < 32 && j % 2 == 0) begin elig = 1; slot = j / 2; end
      end
      if (k == 1) begin
        if (P <= 8 && j < 8) begin elig = 1; slot = j; end
        if (P > 8 && j < 24 && j % 3 == 0) begin elig = 1; slot = j / 3; end
      end
      inv = elig && ($countones(d ^ prev) > 4);
      drv = inv ? ~d : d;
      pay[j] = drv;
      prev = drv;
      if (inv) exp_flags[slot] = 1'b1;
    end
    for (int b = 0; b < 64; b++) exp_s[b] = 8'h00;
    exp_s[0] = {line[7:2], exp_mode};
    for (int m = 0; m < k; m++) exp_s[1+m] = exp_flags[8*m +: 8];
    for (int j = 0; j < P; j++) exp_s[1+k+j] = pay[j];
  endfunction

  task automatic run_line(input logic [511:0] line, input int len_raw,
                          input bit inject, input string tag);
    int cnt = 0;
    int wd = 0;
    int first_bad = -1;
    model(line, len_raw);
    @(negedge clk);
    line_i  = line;
    len_i   = 7'(len_raw);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    line_i  = ~line;
    len_i   = 7'd1;
    while (!done_o && wd < 400) begin
      if (inject && wd == 5) start_i = 1'b1;    // R8: strobe while busy
      if (inject && wd == 6) start_i = 1'b0;
      if (out_valid_o) begin
        if (cnt < 64) got_s[cnt] = out_byte_o;
        cnt++;
      end
      @(negedge clk);
      wd++;
    end
    if (!done_o) begin
      hung = 1;
      check(0, tag, "watchdog", 32'(wd), 32'd400);
      return;
    end
    check(mode_o == exp_mode, "R1", {tag, " mode"}, 32'(mode_o), 32'(exp_mode));
    check(total_len_o == exp_total, "R1", {tag, " total"}, 32'(total_len_o), 32'(exp_total));
    check(cnt == int'(exp_total), "R7", {tag, " beat count"}, 32'(cnt), 32'(exp_total));
    check(flags_o == exp_flags, "R6", {tag, " flags"}, 32'(flags_o), 32'(exp_flags));
    for (int b = 0; b < cnt && b < 64; b++)
      if (got_s[b] !== exp_s[b] && first_bad < 0) first_bad = b;
    if (first_bad < 0)
      check(1, "R2", tag, 0, 0);
    else
      check(0, "R2", {tag, $sformatf(" beat %0d", first_bad)},
            32'(got_s[first_bad]), 32'(exp_s[first_bad]));
    @(negedge clk);
    check(!done_o && !busy_o, "R7", {tag, " done pulse width"}, 32'(done_o), 0);
  endtask

  initial begin
    logic [511:0] ln;
    void'($urandom(32'd4242));
    rst = 1'b1; start_i = 1'b0; len_i = '0; line_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(!busy_o && !out_valid_o && !done_o && mode_o == 2'd0 && total_len_o == 7'd0,
          "R9", "reset outputs", {busy_o, out_valid_o, done_o, mode_o, total_len_o}, 0);

    // R3 tie: payload 0F (4 toggles from 00 -> unchanged), then F0 (8 toggles -> inverted)
    ln = '0; ln[7:0] = 8'hA7; ln[15:8] = 8'h0F; ln[23:16] = 8'hF0;
    run_line(ln, 3, 0, "R3 tie");
    check(flags_o == 24'h000002, "R3", "tie flag pattern", 32'(flags_o), 32'h2);
    // R4 chained reference: 1F inverted to E0, then E0 matches driven ref -> unchanged
    ln = '0; ln[15:8] = 8'h1F; ln[23:16] = 8'hE0;
    run_line(ln, 3, 0, "R4 chain");
    check(flags_o == 24'h000001, "R4", "chain flag pattern", 32'(flags_o), 32'h1);
    // R5 coverage corners
    ln = '0;
    for (int n = 1; n < 64; n++) ln[8*n +: 8] = (n % 2) ? 8'hFF : 8'h00;
    run_line(ln, 30, 0, "R5 alternate");
    run_line(ln, 23, 0, "R5 every-third");
    run_line(ln, 14, 0, "R5 mode2 full");
    run_line(ln, 40, 0, "R5 mode0 aligned");
    run_line(ln, 61, 0, "R5 mode3 long");
    run_line(ln, 64, 0, "R1 full line");
    run_line(ln, 1, 0, "R1 header only");
    // R10 clamps
    run_line(ln, 0, 0, "R10 zero len");
    run_line(ln, 100, 0, "R10 long len");
    // R8 start while busy is ignored
    run_line(ln, 37, 1, "R8 busy start");

    for (int t = 0; t < 24 && !hung; t++) begin
      for (int w = 0; w < 16; w++) ln[32*w +: 32] = $urandom();
      if (t % 4 == 0) for (int n = 0; n < 64; n++) ln[8*n +: 8] = ln[8*n +: 8] & 8'h03;
      run_line(ln, 1 + int'($urandom_range(0, 63)), (t % 5 == 2), "R3 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule